// File: doc/BRIEF.md
# Integer ALU with Overflow Detection

This block is the 32-bit integer arithmetic and logic unit of a simple load/store core. It takes two operands and the 6-bit function field of a register-register instruction. From these it produces a result word, an equality flag and a signed-overflow flag. Immediates are widened by the decode stage before they get here. Multiply, divide, shifts, traps and branch decisions are handled elsewhere.

The operation is decoded directly from the native function field. A single adder serves both additions and subtractions. A subtraction is formed as `a + ~b` with the low carry-in set to 1. The adder exposes the carry into its top bit and the carry out of it. Signed overflow is the XOR of those two carries. The same overflow term corrects the signed less-than compare. The equality flag is a zero test on a dedicated `a - b` difference.

The result and both flags are captured in an output register. They therefore appear one clock after the inputs are presented. An active-low reset clears all three outputs.

Top module: `int_alu`

## Requirements
- R1: Function 100000 (ADD) and 100001 (ADDU) return `a + b` modulo 2^32.
- R2: Function 100010 (SUB) and 100011 (SUBU) return `a - b` modulo 2^32.
- R3: Function 100100 returns `a & b`, 100101 returns `a | b`, 100110 returns `a ^ b` and 100111 returns `~(a | b)`.
- R4: For ADD, the overflow output is 1 exactly when both operands share a sign and the sum's sign differs from it.
- R5: For SUB, the overflow output is 1 exactly when the operands' signs differ and the difference's sign differs from that of `a`.
- R6: ADDU, SUBU, the four logic functions, SLT and SLTU always report overflow 0.
- R7: Function 101010 (SLT) returns 1 when `a < b` as signed two's-complement numbers, and 0 otherwise. This holds even when `a - b` overflows. Bits 31..1 are 0.
- R8: Function 101011 (SLTU) returns 1 when `a < b` as unsigned numbers, and 0 otherwise. Bits 31..1 are 0.
- R9: For every recognised function, the zero output is 1 exactly when `a - b == 0`, that is, when `a == b`.
- R10: Any other function code gives result 0, zero 0 and overflow 0.
- R11: The outputs show the function of the inputs sampled at the previous rising clock edge. While reset is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| func | input | 6 | Instruction function field |
| result_q | output | 32 | Registered result |
| zero_q | output | 1 | Registered equality flag |
| ovf_q | output | 1 | Registered signed-overflow flag |

## Verification
Each function is driven with small values, equal operands and sign-boundary operands such as 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF.

For overflow, one set of sign pairs overflows and another does not. This separates a correct carry-XOR detector from one that looks only at carry-out or only at the result sign. The unsigned and signed variants get the same operands, so the overflow gating can be seen.

The SLT operands include pairs whose difference overflows. A compare that trusts the difference's sign alone fails on them. The SLTU operands include pairs with the top bit set on one side only, where signed and unsigned answers disagree.

Unused codes next to valid ones (101000, 101100, 000000) show whether the decode is exact.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int FUNC_W = 6;

    localparam logic [FUNC_W-1:0] FN_ADD  = 6'b100000;
    localparam logic [FUNC_W-1:0] FN_ADDU = 6'b100001;
    localparam logic [FUNC_W-1:0] FN_SUB  = 6'b100010;
    localparam logic [FUNC_W-1:0] FN_SUBU = 6'b100011;
    localparam logic [FUNC_W-1:0] FN_AND  = 6'b100100;
    localparam logic [FUNC_W-1:0] FN_OR   = 6'b100101;
    localparam logic [FUNC_W-1:0] FN_XOR  = 6'b100110;
    localparam logic [FUNC_W-1:0] FN_NOR  = 6'b100111;
    localparam logic [FUNC_W-1:0] FN_SLT  = 6'b101010;
    localparam logic [FUNC_W-1:0] FN_SLTU = 6'b101011;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_ADD,
        OP_ADDU,
        OP_SUB,
        OP_SUBU,
        OP_AND,
        OP_OR,
        OP_XOR,
        OP_NOR,
        OP_SLT,
        OP_SLTU
    } alu_op_e;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [FUNC_W-1:0] func,
    output alu_op_e           op,
    output logic              use_sub
);
    always_comb begin
        unique case (func)
            FN_ADD:  op = OP_ADD;
            FN_ADDU: op = OP_ADDU;
            FN_SUB:  op = OP_SUB;
            FN_SUBU: op = OP_SUBU;
            FN_AND:  op = OP_AND;
            FN_OR:   op = OP_OR;
            FN_XOR:  op = OP_XOR;
            FN_NOR:  op = OP_NOR;
            FN_SLT:  op = OP_SLT;
            FN_SLTU: op = OP_SLTU;
            default: op = OP_NONE;
        endcase
    end

    // The adder subtracts for both subtract variants and both compares.
    assign use_sub = (op == OP_SUB) || (op == OP_SUBU) ||
                     (op == OP_SLT) || (op == OP_SLTU);
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              carry_msb_in,
    output logic              carry_out
);
    localparam int LOW_W = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [LOW_W-1:0]  low_sum;
    logic              top_sum;

    // Subtraction: invert b and supply the +1 through the low carry-in.
    assign b_eff = b ^ {DATA_W{sub}};

    assign {carry_msb_in, low_sum} = {1'b0, a[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]}
                                     + {{LOW_W{1'b0}}, sub};
    assign {carry_out, top_sum}    = {1'b0, a[DATA_W-1]} + {1'b0, b_eff[DATA_W-1]}
                                     + {1'b0, carry_msb_in};
    assign sum = {top_sum, low_sum};
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);
    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOR:  res = ~(a | b);
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DATA_W-1:0]     opnd_a,
    input  logic [DATA_W-1:0]     opnd_b,
    input  logic [FUNC_W-1:0]     func,
    output logic [DATA_W-1:0]     result_q,
    output logic                  zero_q,
    output logic                  ovf_q
);
    alu_op_e           op;
    logic              use_sub;
    logic [DATA_W-1:0] arith_sum;
    logic              c_msb_in;
    logic              c_out;
    logic              signed_ovf;
    logic [DATA_W-1:0] logic_res;
    logic [DATA_W-1:0] eq_diff;
    logic [DATA_W-1:0] result_d;
    logic              zero_d;
    logic              ovf_d;

    alu_decode u_decode (
        .func    (func),
        .op      (op),
        .use_sub (use_sub)
    );

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a            (opnd_a),
        .b            (opnd_b),
        .sub          (use_sub),
        .sum          (arith_sum),
        .carry_msb_in (c_msb_in),
        .carry_out    (c_out)
    );

    alu_logic #(.DATA_W(DATA_W)) u_logic (
        .op  (op),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (logic_res)
    );

    assign signed_ovf = c_msb_in ^ c_out;
    assign eq_diff    = opnd_a - opnd_b;

    always_comb begin
        result_d = '0;
        ovf_d    = 1'b0;
        zero_d   = (op != OP_NONE) && (eq_diff == '0);
        unique case (op)
            OP_ADD, OP_SUB: begin
                result_d = arith_sum;
                ovf_d    = signed_ovf;
            end
            OP_ADDU, OP_SUBU: result_d = arith_sum;
            OP_AND, OP_OR, OP_XOR, OP_NOR: result_d = logic_res;
            OP_SLT:  result_d = {{(DATA_W-1){1'b0}}, arith_sum[DATA_W-1] ^ signed_ovf};
            OP_SLTU: result_d = {{(DATA_W-1){1'b0}}, ~c_out};
            default: result_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            zero_q   <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            result_q <= result_d;
            zero_q   <= zero_d;
            ovf_q    <= ovf_d;
        end
    end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [FUNC_W-1:0] func,
    input logic [DATA_W-1:0] result_q,
    input logic              zero_q,
    input logic              ovf_q
);
    logic known_fn;
    logic cmp_fn;
    logic quiet_fn;

    assign known_fn = (func inside {FN_ADD, FN_ADDU, FN_SUB, FN_SUBU, FN_AND,
                                    FN_OR, FN_XOR, FN_NOR, FN_SLT, FN_SLTU});
    assign cmp_fn   = (func == FN_SLT) || (func == FN_SLTU);
    assign quiet_fn = known_fn && (func != FN_ADD) && (func != FN_SUB);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_fn |=> !ovf_q); // R6

    AST_CMP_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_fn |=> (result_q[DATA_W-1:1] == '0)); // R7

    AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !known_fn |=> (result_q == '0) && !zero_q && !ovf_q); // R10

    AST_EQUAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (known_fn && (opnd_a == opnd_b)) |=> zero_q); // R9

    AST_UNEQUAL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (opnd_a != opnd_b) |=> !zero_q); // R9

    AST_ADD_SAME_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (func == FN_ADD && opnd_a[DATA_W-1] != opnd_b[DATA_W-1]) |=> !ovf_q); // R4
endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .func     (func),
    .result_q (result_q),
    .zero_q   (zero_q),
    .ovf_q    (ovf_q)
);

// File: tb/int_alu_tb.sv
module int_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [5:0]  func = '0;
    logic [31:0] result_q;
    logic        zero_q;
    logic        ovf_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        zf;
        logic        vf;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    int_alu u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .func     (func),
        .result_q (result_q),
        .zero_q   (zero_q),
        .ovf_q    (ovf_q)
    );

    function automatic exp_t model(input logic [5:0] f, input logic [31:0] a,
                                   input logic [31:0] b, input string tag);
        exp_t e;
        logic [31:0] s;
        logic [31:0] d;
        logic known;
        s = a + b;
        d = a - b;
        e.res = '0;
        e.vf  = 1'b0;
        e.tag = tag;
        known = 1'b1;
        case (f)
            6'b100000: begin e.res = s; e.vf = (a[31] == b[31]) && (s[31] != a[31]); end
            6'b100001: e.res = s;
            6'b100010: begin e.res = d; e.vf = (a[31] != b[31]) && (d[31] != a[31]); end
            6'b100011: e.res = d;
            6'b100100: e.res = a & b;
            6'b100101: e.res = a | b;
            6'b100110: e.res = a ^ b;
            6'b100111: e.res = ~(a | b);
            6'b101010: e.res = {31'b0, ($signed(a) < $signed(b))};
            6'b101011: e.res = {31'b0, (a < b)};
            default:   known = 1'b0;
        endcase
        e.zf = known && (a == b);
        return e;
    endfunction

    task automatic drive(input logic [5:0] f, input logic [31:0] a,
                         input logic [31:0] b, input string tag);
        @(negedge clk);
        func   = f;
        opnd_a = a;
        opnd_b = b;
        sb_q.push_back(model(f, a, b, tag));
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // Monitor: results appear one edge after the driver's negedge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " result"}, result_q, e.res);
                check({e.tag, " zero"}, {31'b0, zero_q}, {31'b0, e.zf});
                check({e.tag, " ovf"}, {31'b0, ovf_q}, {31'b0, e.vf});
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        func   = 6'b100000;
        opnd_a = 32'h7;
        opnd_b = 32'h3;
        repeat (3) @(negedge clk);
        check("R11 reset result", result_q, 32'h0);
        check("R11 reset zero", {31'b0, zero_q}, 32'h0);
        check("R11 reset ovf", {31'b0, ovf_q}, 32'h0);
        rst_n = 1'b1;

        // R1 add
        drive(6'b100000, 32'd7, 32'd3, "R1 add small");
        drive(6'b100001, 32'hFFFF_FFFF, 32'd1, "R1 addu wrap");
        // R4 signed add overflow both directions and non-overflow
        drive(6'b100000, 32'h7FFF_FFFF, 32'd1, "R4 add pos+pos");
        drive(6'b100000, 32'h8000_0000, 32'hFFFF_FFFF, "R4 add neg+neg");
        drive(6'b100000, 32'hFFFF_FFFF, 32'd1, "R4 add no ovf carry");
        drive(6'b100000, 32'hFFFF_FFFC, 32'hFFFF_FFFB, "R4 add -4+-5");
        // R2 and R5 subtract
        drive(6'b100010, 32'd10, 32'd3, "R2 sub small");
        drive(6'b100011, 32'd0, 32'd1, "R2 subu borrow");
        drive(6'b100010, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R5 sub pos-neg");
        drive(6'b100010, 32'h8000_0000, 32'd1, "R5 sub neg-pos");
        drive(6'b100010, 32'd5, 32'd5, "R5 R9 sub equal");
        // R6 unsigned variants with overflowing operands
        drive(6'b100001, 32'h7FFF_FFFF, 32'd1, "R6 addu");
        drive(6'b100011, 32'h8000_0000, 32'd1, "R6 subu");
        // R3 logic
        drive(6'b100100, 32'hF0F0_1234, 32'hFF00_FF00, "R3 and");
        drive(6'b100101, 32'hF0F0_1234, 32'h0F00_0001, "R3 or");
        drive(6'b100110, 32'hAAAA_5555, 32'hFFFF_0000, "R3 xor");
        drive(6'b100111, 32'h1234_0000, 32'h0000_00FF, "R3 nor");
        drive(6'b100111, 32'h0, 32'h0, "R3 R9 nor equal");
        // R7 signed compare, including overflowing differences
        drive(6'b101010, 32'hFFFF_FFFF, 32'd1, "R7 slt -1<1");
        drive(6'b101010, 32'd1, 32'hFFFF_FFFF, "R7 slt 1<-1");
        drive(6'b101010, 32'h8000_0000, 32'h7FFF_FFFF, "R7 slt min<max");
        drive(6'b101010, 32'h7FFF_FFFF, 32'h8000_0000, "R7 slt max<min");
        drive(6'b101010, 32'h1234, 32'h1234, "R7 slt equal");
        // R8 unsigned compare
        drive(6'b101011, 32'hFFFF_FFFF, 32'd1, "R8 sltu big<1");
        drive(6'b101011, 32'd1, 32'hFFFF_FFFF, "R8 sltu 1<big");
        drive(6'b101011, 32'd0, 32'd0, "R8 sltu 0<0");
        // R9 zero flag on add with equal operands
        drive(6'b100000, 32'h8000_0000, 32'h8000_0000, "R9 add equal");
        // R10 unused codes
        drive(6'b101000, 32'd4, 32'd4, "R10 code 101000");
        drive(6'b101100, 32'hFFFF_FFFF, 32'd1, "R10 code 101100");
        drive(6'b000000, 32'h7FFF_FFFF, 32'd1, "R10 code 000000");
        // R11 back-to-back cycles
        drive(6'b100000, 32'd1, 32'd2, "R11 back1");
        drive(6'b100010, 32'd1, 32'd2, "R11 back2");

        repeat (4) @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R11 pending actual=%0d expected=0", sb_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule